// File: doc/BRIEF.md
# Maskable interrupt entry sequencer

This unit sits beside the instruction sequencer of an 8-bit accumulator-style processor core. It decides when the core services a maskable interrupt. The request line is active low and level sensitive. The sequencer marks the second-to-last and last cycle of every instruction. In the second-to-last cycle the unit samples the request line together with the interrupt-disable flag. A request is honoured only if the line is low at that sample and the flag is clear. In that case the instruction slot that follows the current instruction becomes a seven-cycle interrupt entry sequence instead of an opcode fetch.

The unit owns the interrupt-disable flag. Mask-changing instructions (set, clear, load from the stack) write the flag only in their final cycle, after that instruction's interrupt decision has been taken. A return-from-interrupt load writes the flag in the cycle it is signalled. During the entry sequence the unit presents the status byte to push and the two vector addresses. It also sets the disable flag once the status byte has been pushed. The sequencer keeps the program counter unchanged whenever `seq_active` is high.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset, `i_flag` is 1 and both `seq_active` and `irq_pending` are 0.
- R2: In a cycle with `cyc_penult` high, `irq_pending` is loaded at the clock edge with (irq_n low AND i_flag low). In that cycle's sample, `i_flag` is the value before any update at that edge.
- R3: Requests are never queued. A low pulse on `irq_n` that does not cover a `cyc_penult` cycle leaves `irq_pending` at 0. A low level during the `cyc_penult` cycle alone is enough.
- R4: When `cyc_last` is high and `irq_pending` is 1, `seq_active` rises in the next cycle with `seq_step` 0. The step then counts 0 to 6 on successive cycles, and `seq_active` falls after step 6.
- R5: `mask_op` acts only at the edge ending a `cyc_last` cycle: 0 = no change, 1 = set flag, 2 = clear flag, 3 = load `mask_val`. Because the decision is taken first, a set issued while a request is pending still leads to entry, and the pushed status then shows the flag as 1. A clear or load never lets a request in during its own instruction.
- R6: With `irq_n` held low across a clearing instruction, exactly one more instruction completes before entry begins.
- R7: The disable flag becomes 1 at the edge after step 4, so a line still held low is not taken again after the handler starts.
- R8: During step 4, `push_status` is 1 and `status_out` equals `flags_in` with bit 5 forced to 1, bit 4 (break) forced to 0, and bit 2 replaced by the current `i_flag`.
- R9: `vec_fetch` is 1 only in steps 5 and 6. There `vec_addr` is VEC_ADDR (low byte, default FFFE hex) and VEC_ADDR+1 (high byte). Otherwise `vec_addr` is 0.
- R10: `rti_load` writes `rti_val` into the flag at the edge ending the cycle in which it is high, so a held request is taken right after the returning instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| cyc_penult | input | 1 | Current cycle is the second-to-last of the instruction |
| cyc_last | input | 1 | Current cycle is the last of the instruction |
| mask_op | input | 2 | Flag update applied at the end of the last cycle |
| mask_val | input | 1 | Flag value for mask_op 3 |
| rti_load | input | 1 | Immediate flag load from the stack |
| rti_val | input | 1 | Value for rti_load |
| flags_in | input | 8 | Remaining status flags from the datapath |
| irq_pending | output | 1 | Interrupt decision taken at the last sample |
| seq_active | output | 1 | Entry sequence running; suppresses fetch and PC increment |
| seq_step | output | 3 | Entry cycle index 0..6 |
| push_status | output | 1 | Status byte is pushed this cycle |
| status_out | output | 8 | Status byte to push |
| vec_fetch | output | 1 | Vector byte read this cycle |
| vec_addr | output | 16 | Vector address |
| i_flag | output | 1 | Interrupt-disable flag |

## Verification
On every cycle the assertions check the sampling rule, the absence of any queued request between samples, the step progression and termination of the entry sequence, flag setting after the push, the forced status bits and the vector address range. Only the bench scenarios can show the ordering effects that span instructions: a clear that admits a request one instruction late, a set that still lets a pending request in, an immediate return-time load, and a short pulse that is lost. The bench also runs a behavioural model every clock.

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_n,
  input  logic        cyc_penult,
  input  logic        cyc_last,
  input  logic [1:0]  mask_op,
  input  logic        mask_val,
  input  logic        rti_load,
  input  logic        rti_val,
  input  logic [7:0]  flags_in,
  output logic        irq_pending,
  output logic        seq_active,
  output logic [2:0]  seq_step,
  output logic        push_status,
  output logic [7:0]  status_out,
  output logic        vec_fetch,
  output logic [15:0] vec_addr,
  output logic        i_flag
);
  localparam logic [2:0] PUSH_P = 3'd4;
  localparam logic [2:0] VEC_LO = 3'd5;
  localparam logic [2:0] VEC_HI = 3'd6;

  logic       i_q, pend_q, act_q;
  logic [2:0] step_q;
  logic       start;

  assign start       = cyc_last & pend_q & ~act_q;
  assign push_status = act_q & (step_q == PUSH_P);
  assign vec_fetch   = act_q & (step_q >= VEC_LO);
  assign vec_addr    = vec_fetch ? (VEC_ADDR + {15'd0, step_q == VEC_HI}) : 16'h0000;
  assign status_out  = {flags_in[7:6], 1'b1, 1'b0, flags_in[3], i_q, flags_in[1:0]};

  assign irq_pending = pend_q;
  assign seq_active  = act_q;
  assign seq_step    = step_q;
  assign i_flag      = i_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q    <= 1'b1;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      step_q <= 3'd0;
    end else begin
      if (cyc_penult)
        pend_q <= ~irq_n & ~i_q;
      else if (start)
        pend_q <= 1'b0;

      if (push_status)
        i_q <= 1'b1;
      else if (rti_load)
        i_q <= rti_val;
      else if (cyc_last) begin
        case (mask_op)
          2'd1:    i_q <= 1'b1;
          2'd2:    i_q <= 1'b0;
          2'd3:    i_q <= mask_val;
          default: i_q <= i_q;
        endcase
      end

      if (start) begin
        act_q  <= 1'b1;
        step_q <= 3'd0;
      end else if (act_q) begin
        if (step_q == VEC_HI) begin
          act_q  <= 1'b0;
          step_q <= 3'd0;
        end else begin
          step_q <= step_q + 3'd1;
        end
      end
    end
  end
endmodule

module irq_entry_ctrl_chk #(
  parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_n,
  input logic        cyc_penult,
  input logic        cyc_last,
  input logic [1:0]  mask_op,
  input logic        rti_load,
  input logic        rti_val,
  input logic        irq_pending,
  input logic        seq_active,
  input logic [2:0]  seq_step,
  input logic        push_status,
  input logic [7:0]  status_out,
  input logic        vec_fetch,
  input logic [15:0] vec_addr,
  input logic        i_flag
);
  assert_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_penult && (irq_n || i_flag) |=> !irq_pending);

  assert_no_queue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_penult && !irq_pending |=> !irq_pending);

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active && cyc_last && irq_pending |=> seq_active && seq_step == 3'd0);

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active && seq_step < 3'd6 |=> seq_active && seq_step == $past(seq_step) + 3'd1);

  assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active && seq_step == 3'd6 |=> !seq_active);

  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last && mask_op == 2'd1 && !rti_load && !seq_active |=> i_flag);

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active && seq_step == 3'd4 |=> i_flag);

  assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_status |-> status_out[5:4] == 2'b10 && status_out[2] == i_flag);

  assert_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> vec_addr[15:1] == VEC_ADDR[15:1] && seq_active);

  assert_rti_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rti_load && !push_status |=> i_flag == $past(rti_val));
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .cyc_penult(cyc_penult),
  .cyc_last(cyc_last), .mask_op(mask_op), .rti_load(rti_load), .rti_val(rti_val),
  .irq_pending(irq_pending), .seq_active(seq_active), .seq_step(seq_step),
  .push_status(push_status), .status_out(status_out), .vec_fetch(vec_fetch),
  .vec_addr(vec_addr), .i_flag(i_flag)
);

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_n = 1'b1;
  logic cyc_penult = 1'b0, cyc_last = 1'b0;
  logic [1:0] mask_op = 2'd0;
  logic mask_val = 1'b0, rti_load = 1'b0, rti_val = 1'b0;
  logic [7:0] flags_in = 8'hDB;
  logic irq_pending, seq_active, push_status, vec_fetch, i_flag;
  logic [2:0] seq_step;
  logic [7:0] status_out;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_entry_ctrl i_irq_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .cyc_penult(cyc_penult),
    .cyc_last(cyc_last), .mask_op(mask_op), .mask_val(mask_val),
    .rti_load(rti_load), .rti_val(rti_val), .flags_in(flags_in),
    .irq_pending(irq_pending), .seq_active(seq_active), .seq_step(seq_step),
    .push_status(push_status), .status_out(status_out), .vec_fetch(vec_fetch),
    .vec_addr(vec_addr), .i_flag(i_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: masked flag, decision, entry countdown
  int m_mask = 1, m_dec = 0, m_left = 0;
  always @(posedge clk) begin
    int n_mask, n_dec, n_left, pos;
    if (!rst_n) begin
      m_mask = 1; m_dec = 0; m_left = 0;
    end else begin
      pos = 7 - m_left;
      n_mask = m_mask;
      if (m_left > 0 && pos == 4) n_mask = 1;
      else if (rti_load) n_mask = rti_val;
      else if (cyc_last && mask_op != 0)
        n_mask = (mask_op == 1) ? 1 : (mask_op == 2) ? 0 : mask_val;
      n_dec = m_dec;
      n_left = (m_left > 0) ? m_left - 1 : 0;
      if (cyc_last && m_dec == 1 && m_left == 0) begin
        n_left = 7;
        n_dec = 0;
      end
      if (cyc_penult) n_dec = (irq_n == 0 && m_mask == 0) ? 1 : 0;
      m_mask = n_mask; m_dec = n_dec; m_left = n_left;
    end
    #3;
    if (rst_n && !done) begin
      int p;
      logic [15:0] ev;
      p = 7 - m_left;
      ev = (m_left > 0 && p >= 5) ? 16'hFFFE + 16'(p - 5) : 16'h0000;
      chk(irq_pending == m_dec[0], "R2 model pending", irq_pending, m_dec);
      chk(seq_active == (m_left > 0), "R4 model active", seq_active, m_left > 0);
      if (m_left > 0) chk(seq_step == 3'(p), "R4 model step", seq_step, p);
      chk(i_flag == m_mask[0], "R7 model flag", i_flag, m_mask);
      chk(vec_addr == ev, "R9 model vector", vec_addr, ev);
      if (m_left > 0 && p == 4)
        chk(status_out == {flags_in[7:6], 2'b10, flags_in[3], m_mask[0], flags_in[1:0]},
            "R8 model status", status_out, m_mask);
    end
  end

  task automatic run_instr(input int len, input logic [1:0] op, input logic mv,
                           input logic is_rti, input logic rv, input logic [7:0] lowpat);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      irq_n = ~lowpat[c];
      cyc_penult = (c == len - 2);
      cyc_last = (c == len - 1);
      mask_op = (c == len - 1) ? op : 2'd0;
      mask_val = mv;
      rti_load = is_rti && (c == len - 3);
      rti_val = rv;
    end
  endtask

  task automatic service(input logic exp, input logic [7:0] exp_st, input string tag);
    @(negedge clk);
    cyc_penult = 0; cyc_last = 0; mask_op = 0; rti_load = 0;
    chk(seq_active == exp, tag, seq_active, exp);
    if (exp) begin
      for (int k = 0; k < 7; k++) begin
        if (k > 0) @(negedge clk);
        chk(seq_step == 3'(k), "R4 step order", seq_step, k);
        if (k == 4) begin
          chk(push_status == 1'b1, "R8 push strobe", push_status, 1);
          chk(status_out == exp_st, {"R8 status byte ", tag}, status_out, exp_st);
        end
        if (k == 5) chk(vec_addr == 16'hFFFE && vec_fetch, "R9 vector low", vec_addr, 16'hFFFE);
        if (k == 6) chk(vec_addr == 16'hFFFF && vec_fetch, "R9 vector high", vec_addr, 16'hFFFF);
        if (k < 5) chk(vec_fetch == 1'b0, "R9 no early fetch", vec_fetch, 0);
      end
      @(negedge clk);
      chk(seq_active == 1'b0, "R4 sequence end", seq_active, 0);
      chk(i_flag == 1'b1, "R7 flag set on entry", i_flag, 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(i_flag == 1'b1, "R1 reset flag", i_flag, 1);
    chk(seq_active == 1'b0, "R1 reset active", seq_active, 0);
    chk(irq_pending == 1'b0, "R1 reset pending", irq_pending, 0);
    rst_n = 1'b1;

    // masked request is not taken
    run_instr(2, 2'd0, 0, 0, 0, 8'hFF); service(0, 8'h00, "R2 masked request ignored");
    // clear with line held: clearing instruction itself not interrupted
    run_instr(2, 2'd2, 0, 0, 0, 8'hFF); service(0, 8'h00, "R6 no entry after clear");
    run_instr(2, 2'd0, 0, 0, 0, 8'hFF); service(1, 8'hEB, "R6 entry after one instruction");
    // held line, flag set by entry
    run_instr(2, 2'd0, 0, 0, 0, 8'hFF); service(0, 8'h00, "R7 no re-entry");
    // return load clears flag immediately
    run_instr(6, 2'd0, 0, 1, 0, 8'hFF); service(1, 8'hEB, "R10 entry right after return");
    run_instr(6, 2'd0, 0, 1, 0, 8'h00); service(0, 8'h00, "R10 idle line after return");
    chk(i_flag == 1'b0, "R10 flag restored", i_flag, 0);
    // set instruction racing a request
    run_instr(2, 2'd1, 0, 0, 0, 8'hFF); service(1, 8'hEF, "R5 entry despite set");
    // pulses
    run_instr(6, 2'd0, 0, 1, 0, 8'h00); service(0, 8'h00, "R10 unmask");
    run_instr(4, 2'd0, 0, 0, 0, 8'h01); service(0, 8'h00, "R3 early pulse lost");
    chk(irq_pending == 1'b0, "R3 pending after lost pulse", irq_pending, 0);
    run_instr(4, 2'd0, 0, 0, 0, 8'h04); service(1, 8'hEB, "R3 pulse at sample taken");
    // stack load of flag
    run_instr(3, 2'd3, 0, 0, 0, 8'hFF); service(0, 8'h00, "R5 load not early");
    chk(i_flag == 1'b0, "R5 load value", i_flag, 0);
    run_instr(2, 2'd0, 0, 0, 0, 8'hFF); service(1, 8'hEB, "R5 entry after load");
    run_instr(2, 2'd0, 0, 0, 0, 8'h00); service(0, 8'h00, "R2 idle line");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule